// File: doc/BRIEF.md
# Port-to-Port Mailbox Interrupt

This block raises and retires doorbell interrupts between the two sides of a dual-ported shared memory. Each side owns one mailbox word at the top of the address space: side A receives at the second-highest address and side B at the highest. When one side writes the other side's mailbox word, the receiving side's interrupt line is driven active. The receiving side reads its own mailbox word to retire the interrupt. The mailbox data is held in the shared memory array, which sits outside this block. This block only watches the access strobes of both sides and keeps the two interrupt flags.

All strobes are sampled on the rising clock edge. An access is a single-cycle strobe on one side's control inputs. The interrupt flags are registers, so they follow that edge. An access made while that side's busy input is asserted, or an access to semaphore space, has no effect on either flag.

Top module: `mbx_irq`

## Requirements
- R1: While reset is applied and after it is released, both `a_irq_n` and `b_irq_n` are 1 (inactive) until a setting access occurs.
- R2: A side-A write to address 0x1FFF drives `b_irq_n` to 0 after the sampling edge. A write means `a_sel_n`=0, `a_rd_wr`=0, `a_sem_n`=1 and `a_busy_n`=1.
- R3: A side-B read of address 0x1FFF drives `b_irq_n` to 1 after the sampling edge. A read means `b_sel_n`=0, `b_rd_wr`=1, `b_oe_n`=0, `b_sem_n`=1 and `b_busy_n`=1.
- R4: A side-B write to address 0x1FFE drives `a_irq_n` to 0 after the sampling edge.
- R5: A side-A read of address 0x1FFE drives `a_irq_n` to 1 after the sampling edge.
- R6: An access made while that side's busy input is 0 changes neither interrupt flag.
- R7: When a set and a clear of the same flag are sampled on the same edge, the flag ends up set (irq line 0).
- R8: An access with the semaphore select (`*_sem_n`=0) changes neither interrupt flag.
- R9: None of the following changes either flag: a read with output enable inactive, an access with chip select inactive, a write by a side to its own mailbox address, or an access to any other address.
- R10: With no qualifying access on an edge, both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel_n | input | 1 | Side A chip select, active low |
| a_rd_wr | input | 1 | Side A direction: 1 read, 0 write |
| a_oe_n | input | 1 | Side A output enable, active low |
| a_sem_n | input | 1 | Side A semaphore select, active low |
| a_busy_n | input | 1 | Side A busy indication, active low |
| a_addr | input | 13 | Side A address |
| b_sel_n | input | 1 | Side B chip select, active low |
| b_rd_wr | input | 1 | Side B direction: 1 read, 0 write |
| b_oe_n | input | 1 | Side B output enable, active low |
| b_sem_n | input | 1 | Side B semaphore select, active low |
| b_busy_n | input | 1 | Side B busy indication, active low |
| b_addr | input | 13 | Side B address |
| a_irq_n | output | 1 | Interrupt to side A, active low |
| b_irq_n | output | 1 | Interrupt to side B, active low |

## Verification
Each interrupt line is due one rising edge after the access that moves it: the strobe is sampled on that edge and the flag register updates on the same edge. The driver applies a strobe on a falling edge and pushes the flag pair expected after the next rising edge. The monitor pops that entry 1 ns after the rising edge and compares, so every comparison lands in the cycle the flag is due and before the next strobe is applied. Steps in which a flag must not move are compared in the same way, against the unchanged value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Qualified write strobe: selected, memory space, not held off by busy.
  function automatic logic wr_strobe(input logic sel_n, input logic rd_wr,
                                     input logic sem_n, input logic busy_n);
    return !sel_n && !rd_wr && sem_n && busy_n;
  endfunction

  // Qualified read strobe: as above, plus output enable active.
  function automatic logic rd_strobe(input logic sel_n, input logic rd_wr,
                                     input logic oe_n, input logic sem_n,
                                     input logic busy_n);
    return !sel_n && rd_wr && !oe_n && sem_n && busy_n;
  endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              sel_n,
  input  logic              rd_wr,
  input  logic              oe_n,
  input  logic              sem_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ring_peer,
  output logic              ack_own
);
  import mbx_pkg::*;

  logic hit_peer, hit_own;

  always_comb begin
    hit_peer  = (addr == PEER_BOX);
    hit_own   = (addr == OWN_BOX);
    ring_peer = hit_peer && wr_strobe(sel_n, rd_wr, sem_n, busy_n);
    ack_own   = hit_own  && rd_strobe(sel_n, rd_wr, oe_n, sem_n, busy_n);
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign irq_n_o = !flag_q;

  // R1: flag is idle coming out of reset
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !flag_q);

  // R2/R4 and R7: a set lands on the next edge, even with a clear present
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n_o);

  // R3/R5: a lone clear retires the flag
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n_o);

  // R10: nothing requested, nothing moves
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_n_o));

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel_n,
  input  logic              a_rd_wr,
  input  logic              a_oe_n,
  input  logic              a_sem_n,
  input  logic              a_busy_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_sel_n,
  input  logic              b_rd_wr,
  input  logic              b_oe_n,
  input  logic              b_sem_n,
  input  logic              b_busy_n,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              a_irq_n,
  output logic              b_irq_n
);

  localparam int NSIDE = 2;
  localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_A = BOX_B - 1'b1;

  logic              sel_n  [NSIDE];
  logic              rd_wr  [NSIDE];
  logic              oe_n   [NSIDE];
  logic              sem_n  [NSIDE];
  logic              busy_n [NSIDE];
  logic [ADDR_W-1:0] addr   [NSIDE];
  logic              ring   [NSIDE];  // side p rings the other side
  logic              ack    [NSIDE];  // side p acknowledges its own flag
  logic              irq_n  [NSIDE];

  always_comb begin
    sel_n[0] = a_sel_n;   sel_n[1] = b_sel_n;
    rd_wr[0] = a_rd_wr;   rd_wr[1] = b_rd_wr;
    oe_n[0]  = a_oe_n;    oe_n[1]  = b_oe_n;
    sem_n[0] = a_sem_n;   sem_n[1] = b_sem_n;
    busy_n[0] = a_busy_n; busy_n[1] = b_busy_n;
    addr[0]  = a_addr;    addr[1]  = b_addr;
  end

  for (genvar p = 0; p < NSIDE; p++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_A : BOX_B;
    localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_B : BOX_A;

    mbx_port_dec #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
      .sel_n    (sel_n[p]),
      .rd_wr    (rd_wr[p]),
      .oe_n     (oe_n[p]),
      .sem_n    (sem_n[p]),
      .busy_n   (busy_n[p]),
      .addr     (addr[p]),
      .ring_peer(ring[p]),
      .ack_own  (ack[p])
    );

    mbx_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ring[NSIDE-1-p]),
      .clr_i  (ack[p]),
      .irq_n_o(irq_n[p])
    );

    // R6: a busy side produces no interrupt event
    p_busy_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n[p] |-> (!ring[p] && !ack[p]));

    // R8: semaphore-space accesses produce no interrupt event
    p_sem_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sem_n[p] |-> (!ring[p] && !ack[p]));

    // R9: a deselected side produces no interrupt event
    p_desel_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n[p] |-> (!ring[p] && !ack[p]));
  end

  assign a_irq_n = irq_n[0];
  assign b_irq_n = irq_n[1];

endmodule

// File: tb/mbx_irq_test.sv
`timescale 1ns/1ps
module mbx_irq_test;

  localparam logic [12:0] TOP_B = 13'h1FFF;
  localparam logic [12:0] TOP_A = 13'h1FFE;

  typedef struct {
    logic  a_n;
    logic  b_n;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sel_n = 1'b1, a_rd_wr = 1'b1, a_oe_n = 1'b1, a_sem_n = 1'b1, a_busy_n = 1'b1;
  logic b_sel_n = 1'b1, b_rd_wr = 1'b1, b_oe_n = 1'b1, b_sem_n = 1'b1, b_busy_n = 1'b1;
  logic [12:0] a_addr = '0, b_addr = '0;
  logic a_irq_n, b_irq_n;

  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;
  logic mdl_a = 1'b0, mdl_b = 1'b0;  // model flags, 1 = pending
  exp_t sbq[$];

  always #2.5 clk = !clk;

  mbx_irq uut (
    .clk(clk), .rst_n(rst_n),
    .a_sel_n(a_sel_n), .a_rd_wr(a_rd_wr), .a_oe_n(a_oe_n),
    .a_sem_n(a_sem_n), .a_busy_n(a_busy_n), .a_addr(a_addr),
    .b_sel_n(b_sel_n), .b_rd_wr(b_rd_wr), .b_oe_n(b_oe_n),
    .b_sem_n(b_sem_n), .b_busy_n(b_busy_n), .b_addr(b_addr),
    .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
  );

  // Drive one access cycle on both sides; push the flags due after the edge.
  // Side argument order: sel_n, rd_wr, oe_n, sem_n, busy_n, addr.
  task automatic step(input string tag,
                      input logic as, input logic arw, input logic aoe,
                      input logic asm, input logic abz, input logic [12:0] aad,
                      input logic bs, input logic brw, input logic boe,
                      input logic bsm, input logic bbz, input logic [12:0] bad);
    logic a_write, a_read, b_write, b_read;
    exp_t e;
    @(negedge clk);
    a_sel_n = as; a_rd_wr = arw; a_oe_n = aoe; a_sem_n = asm; a_busy_n = abz; a_addr = aad;
    b_sel_n = bs; b_rd_wr = brw; b_oe_n = boe; b_sem_n = bsm; b_busy_n = bbz; b_addr = bad;
    a_write = (as == 0) && (arw == 0) && (asm == 1) && (abz == 1);
    a_read  = (as == 0) && (arw == 1) && (aoe == 0) && (asm == 1) && (abz == 1);
    b_write = (bs == 0) && (brw == 0) && (bsm == 1) && (bbz == 1);
    b_read  = (bs == 0) && (brw == 1) && (boe == 0) && (bsm == 1) && (bbz == 1);
    if (b_write && bad == TOP_A)     mdl_a = 1'b1;
    else if (a_read && aad == TOP_A) mdl_a = 1'b0;
    if (a_write && aad == TOP_B)     mdl_b = 1'b1;
    else if (b_read && bad == TOP_B) mdl_b = 1'b0;
    e.a_n = !mdl_a; e.b_n = !mdl_b; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 1,1,1,1,1, 13'h0000, 1,1,1,1,1, 13'h0000);
  endtask

  // Monitor: compare 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_cmp++;
        if (a_irq_n !== e.a_n || b_irq_n !== e.b_n) begin
          n_bad++;
          $display("FAIL %s: a_irq_n/b_irq_n got %b%b expected %b%b",
                   e.tag, a_irq_n, b_irq_n, e.a_n, e.b_n);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;  // R1: lines idle during reset
    if (a_irq_n !== 1'b1 || b_irq_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 in reset: got %b%b expected 11", a_irq_n, b_irq_n);
    end
    @(negedge clk); rst_n = 1'b1;
    idle("R1 after reset");
    idle("R10 idle hold");
    // R2: A writes B's mailbox
    step("R2 A write 1FFF", 0,0,1,1,1, TOP_B, 1,1,1,1,1, 13'h0);
    idle("R10 hold set");
    // R9: read without output enable
    step("R9 B read oe off", 1,1,1,1,1, 13'h0, 0,1,1,1,1, TOP_B);
    // R3: B reads its mailbox
    step("R3 B read 1FFF", 1,1,1,1,1, 13'h0, 0,1,0,1,1, TOP_B);
    // R4: B writes A's mailbox
    step("R4 B write 1FFE", 1,1,1,1,1, 13'h0, 0,0,1,1,1, TOP_A);
    // R6: A read while busy
    step("R6 A read busy", 0,1,0,1,0, TOP_A, 1,1,1,1,1, 13'h0);
    // R8: A read in semaphore space
    step("R8 A read sem", 0,1,0,0,1, TOP_A, 1,1,1,1,1, 13'h0);
    // R5: A reads its mailbox
    step("R5 A read 1FFE", 0,1,0,1,1, TOP_A, 1,1,1,1,1, 13'h0);
    // R6: A write while busy
    step("R6 A write busy", 0,0,1,1,0, TOP_B, 1,1,1,1,1, 13'h0);
    // R8: A write in semaphore space
    step("R8 A write sem", 0,0,1,0,1, TOP_B, 1,1,1,1,1, 13'h0);
    // R9: deselected B write
    step("R9 B write desel", 1,1,1,1,1, 13'h0, 1,0,1,1,1, TOP_A);
    // R9: each side writes its own mailbox
    step("R9 own mailbox", 0,0,1,1,1, TOP_A, 0,0,1,1,1, TOP_B);
    // R9: neighbouring address
    step("R9 other addr", 0,0,1,1,1, 13'h1FFD, 0,0,1,1,1, 13'h0000);
    // R7: set and clear of B's flag together
    step("R7 set+clr B", 0,0,1,1,1, TOP_B, 0,1,0,1,1, TOP_B);
    step("R7 set+clr B again", 0,0,1,1,1, TOP_B, 0,1,0,1,1, TOP_B);
    step("R3 B clear", 1,1,1,1,1, 13'h0, 0,1,0,1,1, TOP_B);
    // R7: set and clear of A's flag together
    step("R7 set+clr A", 0,1,0,1,1, TOP_A, 0,0,1,1,1, TOP_A);
    step("R8 A sem read no clr", 0,1,0,0,1, TOP_A, 1,1,1,1,1, 13'h0);
    // R2+R4 both at once
    step("R2 R4 both set", 0,0,1,1,1, TOP_B, 0,0,1,1,1, TOP_A);
    // R6: B busy read does not clear
    step("R6 B read busy", 1,1,1,1,1, 13'h0, 0,1,0,1,0, TOP_B);
    // R3 + R5 both clear
    step("R3 R5 both clear", 0,1,0,1,1, TOP_A, 0,1,0,1,1, TOP_B);
    idle("R10 final");
    @(posedge clk); #2;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule